// File: doc/BRIEF.md
# Programmable Clock Output Divider

This block produces several gated clock outputs. Each output has its own 8-bit control word. The word picks one of two source clocks, an optional prescale ratio, a power-of-two divide ratio and an enable. The two sources are a 32768 Hz low-speed clock and a 4 MHz high-speed clock. They reach the block as single-cycle tick strobes in the system clock domain. Each tick marks one edge of its source, so a source produces two ticks per period. Every output is a registered level toggled by a per-channel counter, which gives a 50% duty cycle for every legal ratio.

Software writes and reads the control words over a simple address/data port. The words sit at consecutive addresses starting at zero. A running channel keeps its current ratio and source until its next rising edge. At that edge it takes up whatever the register holds, so a reprogram never truncates a half period or produces a runt pulse. The total ratio is the prescale factor times 2^n. The prescale factor is 1, 2, 4, 8, 16, 32 or 64 for codes 0 to 6 and 122 for code 7, and it counts only when the high-speed source is picked.

Top module: `clkdiv_top`

## Requirements
- R1: After reset every clock output is low and every control word reads back as 0x00.
- R2: A write to address a < NUM_OUT stores wr_data in word a, and reading address a returns the last value written there. A write to an address >= NUM_OUT changes nothing, and reading such an address returns 0x00.
- R3: Bit 0 of a word is the enable. While it is 0 the channel's output is low from the cycle after the register holds 0, and it stays low however the ticks behave.
- R4: Bit 4 picks the source. Value 0 counts lo_tick (the 32768 Hz source) and value 1 counts hi_tick (the 4 MHz source).
- R5: Bits 3:1 hold a divide code n that multiplies the ratio by 2^n. Code 0 leaves the prescaled source undivided.
- R6: Bits 7:5 hold a prescale code used when bit 4 is 1. Codes 0 to 6 give a factor of 2^code, and code 7 gives a factor of 122.
- R7: When bit 4 is 0 the prescale code has no effect, and the factor is 1.
- R8: Each high phase and each low phase of a running output lasts exactly ratio ticks of the chosen source, so the duty cycle is 50%. Here ratio is the prescale factor times 2^n.
- R9: A change to source, prescale or divide code written while the output runs takes effect at the output's next rising edge. The half period in progress and the low phase after it keep the old ratio.
- R10: Channels are independent. Each output follows only its own word, whatever is written to the others.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the control words |
| wr_addr | input | ADDR_W | Word index for a write |
| wr_data | input | 8 | Control word value to store |
| rd_addr | input | ADDR_W | Word index for a read |
| rd_data | output | 8 | Stored control word, or 0x00 when the index is out of range |
| lo_tick | input | 1 | One pulse per edge of the 32768 Hz source |
| hi_tick | input | 1 | One pulse per edge of the 4 MHz source |
| clk_out | output | NUM_OUT | Divided, gated clock outputs |

## Verification
On the high-speed source the bench sweeps every prescale code against the lowest divide codes. On the low-speed source it sweeps every divide code with a nonzero prescale code present. Because the two tick streams run at different rates, every measured high and low width shows the factor that produced it. The lo stream has three system cycles per tick and the hi stream one, so the widths also reveal which source was counted and whether a prescale code that should be ignored was applied. A mid-phase reprogram checks that the old ratio finishes before the new one begins. Disable, out-of-range access and parallel channels with different words check gating, decoding and independence.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    localparam int DIV_BITS = 3;
    localparam int PRE_TOP  = 122;
    localparam int CNT_W    = $clog2(PRE_TOP << ((1 << DIV_BITS) - 1)) + 1;

    // Field order is the register layout decoded by the channels.
    typedef struct packed {
        logic [2:0]          pre;
        logic                sel;
        logic [DIV_BITS-1:0] div;
        logic                en;
    } ctl_t;

    function automatic logic [CNT_W-1:0] half_ticks(ctl_t c);
        logic [CNT_W-1:0] p;
        if (!c.sel)
            p = CNT_W'(1);
        else if (c.pre == 3'd7)
            p = CNT_W'(PRE_TOP);
        else
            p = CNT_W'(1) << c.pre;
        return p << c.div;
    endfunction

endpackage

// File: rtl/clkdiv_regs.sv
module clkdiv_regs
    import clkdiv_pkg::*;
#(
    parameter int NUM_OUT = 3,
    parameter int ADDR_W  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [7:0]           wr_data,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [7:0]           rd_data,
    output logic [NUM_OUT*8-1:0] ctl_flat
);

    typedef struct packed {
        logic [NUM_OUT-1:0][7:0] word;
    } reg_st_t;

    reg_st_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en && (int'(wr_addr) < NUM_OUT))
            r_d.word[wr_addr] = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rd_data = 8'h00;
        if (int'(rd_addr) < NUM_OUT)
            rd_data = r_q.word[rd_addr];
    end

    assign ctl_flat = r_q.word;

endmodule

// File: rtl/clkdiv_chan.sv
module clkdiv_chan
    import clkdiv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  ctl_t ctl,
    input  logic lo_tick,
    input  logic hi_tick,
    output logic clk_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             out;
        ctl_t             act;
    } ch_st_t;

    ch_st_t s_d, s_q;
    logic             tick;
    logic [CNT_W-1:0] lim;

    always_comb begin
        s_d  = s_q;
        tick = s_q.act.sel ? hi_tick : lo_tick;
        lim  = half_ticks(s_q.act);
        if (!ctl.en) begin
            s_d = '0;
        end else if (!s_q.act.en) begin
            // first cycle after enable: capture the word, start low
            s_d.act = ctl;
            s_d.cnt = '0;
            s_d.out = 1'b0;
        end else if (tick) begin
            if (s_q.cnt == lim - CNT_W'(1)) begin
                s_d.cnt = '0;
                s_d.out = ~s_q.out;
                // period boundary: the rising edge adopts the new word
                if (!s_q.out)
                    s_d.act = ctl;
            end else begin
                s_d.cnt = s_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign clk_o = s_q.out;

endmodule

// File: rtl/clkdiv_top.sv
module clkdiv_top
    import clkdiv_pkg::*;
#(
    parameter int NUM_OUT = 3,
    parameter int ADDR_W  = (NUM_OUT > 1) ? $clog2(NUM_OUT) + 1 : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [7:0]         wr_data,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [7:0]         rd_data,
    input  logic               lo_tick,
    input  logic               hi_tick,
    output logic [NUM_OUT-1:0] clk_out
);

    logic [NUM_OUT*8-1:0] ctl_flat;

    clkdiv_regs #(.NUM_OUT(NUM_OUT), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .ctl_flat (ctl_flat)
    );

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_ch
        clkdiv_chan u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .ctl     (ctl_t'(ctl_flat[i*8 +: 8])),
            .lo_tick (lo_tick),
            .hi_tick (hi_tick),
            .clk_o   (clk_out[i])
        );
    end

endmodule

// File: rtl/clkdiv_chk.sv
module clkdiv_chk #(
    parameter int NUM_OUT = 3,
    parameter int ADDR_W  = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic [ADDR_W-1:0]    wr_addr,
    input logic [7:0]           wr_data,
    input logic [ADDR_W-1:0]    rd_addr,
    input logic [7:0]           rd_data,
    input logic                 lo_tick,
    input logic                 hi_tick,
    input logic [NUM_OUT-1:0]   clk_out,
    input logic [NUM_OUT*8-1:0] ctl_flat
);

    AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(rd_addr) >= NUM_OUT) |-> (rd_data == 8'h00)); // R2

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_p
        AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && int'(wr_addr) == i) |=> (ctl_flat[i*8 +: 8] == $past(wr_data))); // R2

        AST_OFF_HOLDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            !ctl_flat[i*8] |=> !clk_out[i]); // R3

        AST_RISE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(clk_out[i]) |-> $past(ctl_flat[i*8])); // R3

        AST_EDGE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
            (!$stable(clk_out[i]) && $past(ctl_flat[i*8])) |-> ($past(lo_tick) || $past(hi_tick))); // R8
    end

endmodule

bind clkdiv_top clkdiv_chk #(.NUM_OUT(NUM_OUT), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .lo_tick  (lo_tick),
    .hi_tick  (hi_tick),
    .clk_out  (clk_out),
    .ctl_flat (ctl_flat)
);

// File: tb/clkdiv_top_tb.sv
module clkdiv_top_tb;

    localparam int CLK_PER = 10;
    localparam int NUM_OUT = 3;
    localparam int ADDR_W  = 3;
    localparam int LO_GAP  = 3;
    localparam int LIMIT   = 40000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic lo_tick = 1'b0;
    logic hi_tick = 1'b0;
    logic [NUM_OUT-1:0] clk_out;

    int n_chk = 0;
    int n_bad = 0;
    int phase = 0;

    clkdiv_top #(.NUM_OUT(NUM_OUT), .ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .lo_tick(lo_tick), .hi_tick(hi_tick), .clk_out(clk_out)
    );

    always #(CLK_PER/2) clk = ~clk;

    // lo ticks every LO_GAP cycles, hi ticks every cycle
    initial begin
        forever begin
            @(negedge clk);
            phase   = phase + 1;
            lo_tick = (phase % LO_GAP == 0);
            hi_tick = 1'b1;
        end
    end

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(int a, int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_data = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic int half_cycles(int w);
        int pre, sel, dv, r;
        pre = (w >> 5) & 7;
        sel = (w >> 4) & 1;
        dv  = (w >> 1) & 7;
        r   = sel ? ((pre == 7) ? 122 : (1 << pre)) : 1;
        r   = r << dv;
        return sel ? r : r * LO_GAP;
    endfunction

    // count negedges while output holds value v
    task automatic run_len(int ch, logic v, output int len);
        len = 0;
        while (clk_out[ch] == v && len < LIMIT) begin
            len++;
            @(negedge clk);
        end
    endtask

    task automatic wait_rise(int ch);
        int k;
        k = 0;
        while (clk_out[ch] != 1'b0 && k < LIMIT) begin k++; @(negedge clk); end
        while (clk_out[ch] != 1'b1 && k < LIMIT) begin k++; @(negedge clk); end
    endtask

    task automatic measure(string req, int ch, int w);
        int hi, lo;
        wait_rise(ch);
        run_len(ch, 1'b1, hi);
        run_len(ch, 1'b0, lo);
        check({req, " high"}, hi, half_cycles(w));
        check({req, " low"}, lo, half_cycles(w));
    endtask

    task automatic start(int ch, int w);
        wr(ch, 0);
        wr(ch, w);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PER * 190000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        int lo, hi;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 outputs", int'(clk_out), 0);
        for (int a = 0; a < NUM_OUT; a++) begin
            rd_addr = ADDR_W'(a); #1;
            check("R1 readback", int'(rd_data), 0);
        end

        // R2 readback and out-of-range
        wr(0, 8'hA4); wr(1, 8'h3C); wr(2, 8'hF2); wr(5, 8'h77);
        rd_addr = 0; #1; check("R2 word0", int'(rd_data), 8'hA4);
        rd_addr = 1; #1; check("R2 word1", int'(rd_data), 8'h3C);
        rd_addr = 2; #1; check("R2 word2", int'(rd_data), 8'hF2);
        rd_addr = 5; #1; check("R2 oor read", int'(rd_data), 0);
        rd_addr = 3; #1; check("R2 oor read3", int'(rd_data), 0);
        // R3 enable clear holds outputs low
        repeat (3) @(negedge clk);
        hi = 0;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (clk_out != '0) hi++;
        end
        check("R3 off stays low", hi, 0);

        // R4 R5 R6 R8: high-speed source, every prescale code
        for (int p = 0; p < 8; p++) begin
            for (int d = 0; d < 3; d++) begin
                start(0, (p << 5) | (1 << 4) | (d << 1) | 1);
                measure("R6 R5 R8 hi-source", 0, (p << 5) | (1 << 4) | (d << 1) | 1);
            end
        end
        // R4 R5 R7: low-speed source, every divide code, prescale ignored
        for (int d = 0; d < 8; d++) begin
            start(0, ((d % 2 ? 7 : 3) << 5) | (d << 1) | 1);
            measure("R7 R5 R4 lo-source", 0, ((d % 2 ? 7 : 3) << 5) | (d << 1) | 1);
        end

        // R9 reprogram mid-high-phase: old ratio finishes, new at next rise
        start(0, (1 << 4) | (2 << 1) | 1);
        wait_rise(0);
        wr(0, (1 << 4) | (3 << 1) | 1);
        while (clk_out[0] == 1'b1) @(negedge clk);
        run_len(0, 1'b0, lo);
        check("R9 low keeps old", lo, 4);
        run_len(0, 1'b1, hi);
        check("R9 high takes new", hi, 8);

        // R3 disable while running
        wr(0, 0);
        @(negedge clk);
        hi = 0;
        for (int k = 0; k < 300; k++) begin
            if (clk_out[0]) hi++;
            @(negedge clk);
        end
        check("R3 disable low", hi, 0);

        // R10 channels independent
        start(1, (2 << 5) | (1 << 1) | 1);
        start(2, (7 << 5) | (1 << 4) | 1);
        measure("R10 ch1", 1, (2 << 5) | (1 << 1) | 1);
        measure("R10 ch2", 2, (7 << 5) | (1 << 4) | 1);
        check("R10 ch0 idle", int'(clk_out[0]), 0);
        wr(1, (1 << 4) | 1);
        measure("R10 ch2 after ch1 write", 2, (7 << 5) | (1 << 4) | 1);
        measure("R10 ch1 new", 1, (1 << 4) | 1);

        finish_run();
    end

endmodule